// File: doc/BRIEF.md
# Network Interrupt Moderation Controller

This block gathers interrupt causes from a network interface and drives a single level-sensitive interrupt line towards the host. It holds a pending-cause register and a mask register. The line is high only while at least one pending cause is unmasked. Causes arrive as strobes, each with an urgent flag. A non-urgent cause must also respect a throttle interval, which bounds how often the line may rise. An urgent cause bypasses that interval.

Four delay timers turn descriptor activity into delayed causes. Receive has a restartable short timer and a run-to-completion absolute timer, and both set the receive-threshold cause. Transmit has the same pair, and both set the transmit-written-back cause. Every timer expiry is posted as urgent. Software writes the mask, reads the cause register (which clears it), sets the throttle interval and loads each timer's reload value. Register decode and DMA stay outside. All pins are plain control strobes with no handshake. A strobe is taken on the clock edge where it is high.

Top module: `nic_irq_moderator`

## Requirements
- R1: After reset the line is low, pending and mask are zero, all timers are idle and throttling is disabled (interval 0).
- R2: A post ORs `post_cause` into pending at the next edge whether or not it is masked. `cause_rdata` always shows pending, and a masked post leaves the line low.
- R3: A read (`cause_rd`) clears pending at that edge and the line drops at the same edge. Causes posted in the same cycle are kept, and they assert the line again by the normal rules.
- R4: A mask write replaces the mask. At that edge the line becomes the OR of (pending AND new mask), whatever the throttle state.
- R5: An urgent post whose cause is unmasked raises the line at the next edge, even while the throttle interval runs.
- R6: A non-urgent unmasked post raises the line at the next edge if no throttle interval runs. Otherwise the rise waits for the interval to end, and it happens then only if an unmasked cause is still pending.
- R7: A 16-bit interval N loaded by `thr_wr` makes every rise of the line start a window of N*UNIT_CYC cycles. No non-urgent rise happens until that window ends. An N of 0 disables throttling.
- R8: Expiry of timer 0 (receive short) or timer 1 (receive absolute) sets cause bit RX_BIT (default 4). Expiry of timer 2 (transmit short) or timer 3 (transmit absolute) sets cause bit TX_BIT (default 0). Each expiry is treated as urgent. Bit i of `tmr_kick` and of `tmr_load_wr` selects timer i.
- R9: Each timer counts down from its 16-bit reload value. Its cause appears in pending R+1 cycles after the kick edge, where R is the reload value. A short timer (0 or 2) reloads on every kick.
- R10: An absolute timer (1 or 3) ignores kicks while it is running. It restarts only from idle.
- R11: The line is never high unless pending AND mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_valid | input | 1 | Cause strobe |
| post_urgent | input | 1 | Strobed cause bypasses the throttle |
| post_cause | input | NCAUSE | Cause bits to set |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | NCAUSE | New mask value |
| cause_rd | input | 1 | Read-to-clear strobe of pending |
| cause_rdata | output | NCAUSE | Current pending causes |
| thr_wr | input | 1 | Throttle interval write strobe |
| thr_wdata | input | IVL_W | Throttle interval in units |
| tmr_load_wr | input | 4 | Per-timer reload write strobes |
| tmr_load_val | input | TMR_W | Reload value |
| tmr_kick | input | 4 | Per-timer start event |
| irq | output | 1 | Interrupt line to host |

## Verification
The bench builds the block with UNIT_CYC set to 4 instead of the default 51. A throttle interval of 3 then lasts 12 cycles, so a deferred non-urgent rise and an urgent rise inside a running window both fit in a short run. The cause bits keep their defaults, 4 for receive and 0 for transmit. Small reload values let the bench see a short-timer restart and an ignored absolute-timer kick cycle by cycle.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int NUM_TMR = 4;
  typedef enum logic [1:0] {
    TMR_RX_SHORT = 2'd0,
    TMR_RX_ABS   = 2'd1,
    TMR_TX_SHORT = 2'd2,
    TMR_TX_ABS   = 2'd3
  } tmr_id_e;
endpackage

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
  parameter int W       = 16,
  parameter bit RESTART = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_wr,
  input  logic [W-1:0] load_val,
  input  logic         kick,
  output logic         fire
);
  logic [W-1:0] reload_q, cnt_q;
  logic         act_q;
  logic         start;

  assign fire = act_q && (cnt_q == '0);

  generate
    if (RESTART) begin : g_short
      assign start = kick;
    end else begin : g_abs
      assign start = kick && !act_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      act_q    <= 1'b0;
    end else begin
      if (load_wr) reload_q <= load_val;
      if (start) begin
        cnt_q <= reload_q;
        act_q <= 1'b1;
      end else if (fire) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        cnt_q <= cnt_q - W'(1);
      end
    end
  end
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
  parameter int IVL_W    = 16,
  parameter int UNIT_CYC = 51
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ivl_wr,
  input  logic [IVL_W-1:0] ivl_val,
  input  logic             rise,
  output logic             busy
);
  localparam int CNT_W = IVL_W + $clog2(UNIT_CYC + 1) + 1;

  logic [IVL_W-1:0] ivl_q;
  logic [CNT_W-1:0] cnt_q, span;

  assign span = CNT_W'(ivl_q) * CNT_W'(UNIT_CYC);
  assign busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ivl_wr) ivl_q <= ivl_val;
      if (rise && (ivl_q != '0)) cnt_q <= span - CNT_W'(1);
      else if (busy)             cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/nic_irq_moderator.sv
module nic_irq_moderator
  import nic_irq_pkg::*;
#(
  parameter int NCAUSE   = 8,
  parameter int TMR_W    = 16,
  parameter int IVL_W    = 16,
  parameter int UNIT_CYC = 51,
  parameter int RX_BIT   = 4,
  parameter int TX_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_valid,
  input  logic              post_urgent,
  input  logic [NCAUSE-1:0] post_cause,
  input  logic              mask_wr,
  input  logic [NCAUSE-1:0] mask_wdata,
  input  logic              cause_rd,
  output logic [NCAUSE-1:0] cause_rdata,
  input  logic              thr_wr,
  input  logic [IVL_W-1:0]  thr_wdata,
  input  logic [NUM_TMR-1:0] tmr_load_wr,
  input  logic [TMR_W-1:0]  tmr_load_val,
  input  logic [NUM_TMR-1:0] tmr_kick,
  output logic              irq
);
  logic [NCAUSE-1:0]  pend_q, mask_q, pend_nx, mask_nx, tmr_cause, new_cause;
  logic [NUM_TMR-1:0] fire;
  logic               irq_q, irq_nx, hit, urgent_now, thr_busy, rise;

  // Even indices restart on every kick, odd indices run to completion.
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    irq_delay_timer #(.W(TMR_W), .RESTART((i % 2) == 0)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .load_wr(tmr_load_wr[i]), .load_val(tmr_load_val),
      .kick(tmr_kick[i]), .fire(fire[i])
    );
  end

  always_comb begin
    tmr_cause = '0;
    tmr_cause[RX_BIT] = fire[TMR_RX_SHORT] | fire[TMR_RX_ABS];
    tmr_cause[TX_BIT] = tmr_cause[TX_BIT] | fire[TMR_TX_SHORT] | fire[TMR_TX_ABS];
  end

  assign new_cause  = (post_valid ? post_cause : '0) | tmr_cause;
  assign urgent_now = (post_valid && post_urgent) || (|fire);
  assign pend_nx    = (cause_rd ? '0 : pend_q) | new_cause;
  assign mask_nx    = mask_wr ? mask_wdata : mask_q;
  assign hit        = |(pend_nx & mask_nx);
  assign irq_nx     = mask_wr ? hit : (hit && (irq_q || urgent_now || !thr_busy));
  assign rise       = irq_nx && !irq_q;

  irq_throttle #(.IVL_W(IVL_W), .UNIT_CYC(UNIT_CYC)) u_thr (
    .clk(clk), .rst_n(rst_n), .ivl_wr(thr_wr), .ivl_val(thr_wdata),
    .rise(rise), .busy(thr_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_nx;
      mask_q <= mask_nx;
      irq_q  <= irq_nx;
    end
  end

  assign cause_rdata = pend_q;
  assign irq         = irq_q;
endmodule

// File: rtl/irq_mod_checker.sv
module irq_mod_checker #(
  parameter int NCAUSE = 8,
  parameter int RX_BIT = 4,
  parameter int TX_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              post_valid,
  input logic              post_urgent,
  input logic [NCAUSE-1:0] post_cause,
  input logic              mask_wr,
  input logic              cause_rd,
  input logic              irq,
  input logic [NCAUSE-1:0] pend_q,
  input logic [NCAUSE-1:0] mask_q,
  input logic [3:0]        fire,
  input logic              thr_busy
);
  assert_line_needs_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(pend_q & mask_q)));

  assert_mask_reeval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (irq == (|(pend_q & mask_q))));

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_rd && !post_valid && (fire == '0)) |=> ((pend_q == '0) && !irq));

  assert_urgent_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_urgent && !mask_wr && (|(post_cause & mask_q))) |=> irq);

  assert_throttle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && thr_busy && !mask_wr && !(post_valid && post_urgent) && (fire == '0)) |=> !irq);

  assert_rx_timer_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire[0] || fire[1]) |=> pend_q[RX_BIT]);

  assert_tx_timer_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire[2] || fire[3]) |=> pend_q[TX_BIT]);
endmodule

bind nic_irq_moderator irq_mod_checker #(
  .NCAUSE(NCAUSE), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_urgent(post_urgent),
  .post_cause(post_cause), .mask_wr(mask_wr), .cause_rd(cause_rd), .irq(irq),
  .pend_q(pend_q), .mask_q(mask_q), .fire(fire), .thr_busy(thr_busy)
);

// File: tb/sim_nic_irq_moderator.sv
module sim_nic_irq_moderator;
  localparam int NC = 8, TW = 16, IW = 16, UNIT = 4, RXB = 4, TXB = 0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic post_valid = 0, post_urgent = 0, mask_wr = 0, cause_rd = 0, thr_wr = 0;
  logic [NC-1:0] post_cause = '0, mask_wdata = '0, cause_rdata;
  logic [IW-1:0] thr_wdata = '0;
  logic [3:0] tmr_load_wr = '0, tmr_kick = '0;
  logic [TW-1:0] tmr_load_val = '0;
  logic irq;

  always #10 clk = ~clk;

  nic_irq_moderator #(.NCAUSE(NC), .TMR_W(TW), .IVL_W(IW), .UNIT_CYC(UNIT),
                      .RX_BIT(RXB), .TX_BIT(TXB)) u0 (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_urgent(post_urgent),
    .post_cause(post_cause), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .cause_rd(cause_rd), .cause_rdata(cause_rdata), .thr_wr(thr_wr),
    .thr_wdata(thr_wdata), .tmr_load_wr(tmr_load_wr), .tmr_load_val(tmr_load_val),
    .tmr_kick(tmr_kick), .irq(irq)
  );

  // Behavioural reference
  logic [NC-1:0] m_pend, m_mask;
  bit m_irq;
  int m_ivl, m_win;
  int t_cnt[4], t_rel[4];
  bit t_run[4];

  string tag = "R1";
  int vectors = 0, errs = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_mask = '0; m_irq = 0; m_ivl = 0; m_win = 0;
      for (int i = 0; i < 4; i++) begin t_cnt[i] = 0; t_rel[i] = 0; t_run[i] = 0; end
    end else begin
      bit ex[4];
      bit urg, h, nxt;
      logic [NC-1:0] incoming, np, nm;
      for (int i = 0; i < 4; i++) ex[i] = t_run[i] && (t_cnt[i] == 0);
      incoming = post_valid ? post_cause : '0;
      if (ex[0] || ex[1]) incoming[RXB] = 1'b1;
      if (ex[2] || ex[3]) incoming[TXB] = 1'b1;
      urg = (post_valid && post_urgent) || ex[0] || ex[1] || ex[2] || ex[3];
      np  = cause_rd ? incoming : (m_pend | incoming);
      nm  = mask_wr ? mask_wdata : m_mask;
      h   = (np & nm) != '0;
      if (mask_wr)                         nxt = h;
      else if (!h)                         nxt = 0;
      else if (m_irq || urg || m_win == 0) nxt = 1;
      else                                 nxt = 0;
      if (nxt && !m_irq && m_ivl != 0) m_win = m_ivl * UNIT - 1;
      else if (m_win > 0)              m_win = m_win - 1;
      if (thr_wr) m_ivl = int'(thr_wdata);
      for (int i = 0; i < 4; i++) begin
        if (tmr_kick[i] && ((i % 2) == 0 || !t_run[i])) begin
          t_cnt[i] = t_rel[i]; t_run[i] = 1;
        end else if (ex[i]) t_run[i] = 0;
        else if (t_run[i]) t_cnt[i] = t_cnt[i] - 1;
        if (tmr_load_wr[i]) t_rel[i] = int'(tmr_load_val);
      end
      m_pend = np; m_mask = nm; m_irq = nxt;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (irq !== m_irq) begin
        errs++;
        $display("FAIL %s: irq actual %0b expected %0b at %0t", tag, irq, m_irq, $time);
      end
      if (cause_rdata !== m_pend) begin
        errs++;
        $display("FAIL %s: cause_rdata actual %h expected %h at %0t", tag, cause_rdata, m_pend, $time);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  endtask

  task automatic step(int n); repeat (n) @(negedge clk); endtask

  task automatic post(logic [NC-1:0] c, bit u);
    post_valid = 1; post_cause = c; post_urgent = u;
    step(1); post_valid = 0; post_urgent = 0; post_cause = '0;
  endtask

  task automatic wmask(logic [NC-1:0] m);
    mask_wr = 1; mask_wdata = m; step(1); mask_wr = 0;
  endtask

  task automatic rdclr(); cause_rd = 1; step(1); cause_rd = 0; endtask

  task automatic wthr(int v); thr_wr = 1; thr_wdata = IW'(v); step(1); thr_wr = 0; endtask

  task automatic tload(int i, int v);
    tmr_load_wr[i] = 1'b1; tmr_load_val = TW'(v); step(1); tmr_load_wr = '0;
  endtask

  task automatic kick(int i); tmr_kick[i] = 1'b1; step(1); tmr_kick = '0; endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not end, actual running expected finished");
      finish_run();
    end
  end

  initial begin
    step(3); rst_n = 1; tag = "R1"; step(2);
    tag = "R2";  post(8'h06, 0); step(3);
    tag = "R4";  wmask(8'h04); step(2); wmask(8'h00); step(2); wmask(8'hFF); step(2);
    tag = "R3";  rdclr(); step(2);
    cause_rd = 1; post(8'h10, 0); cause_rd = 0; step(2); rdclr(); step(1);
    tag = "R7";  wthr(3); post(8'h01, 0); step(1); rdclr();
    tag = "R6";  post(8'h02, 0); step(14); rdclr(); step(1);
    tag = "R5";  post(8'h08, 1); step(2); rdclr(); post(8'h20, 0); step(2);
    tag = "R6";  step(14); rdclr(); step(14); post(8'h40, 0); step(2); rdclr();
    tag = "R7";  wthr(0); post(8'h01, 0); step(1); rdclr(); post(8'h02, 0); step(2); rdclr();
    tag = "R8";  tload(0, 5); tload(2, 0); kick(2); step(3); rdclr(); step(1);
    tag = "R9";  kick(0); step(3); kick(0); step(10); rdclr(); step(1);
    tag = "R10"; tload(1, 8); kick(1); step(3); kick(1); step(12); rdclr(); step(1);
    tload(3, 2); kick(3); kick(3); step(6); rdclr(); step(1);
    tag = "R11"; wmask(8'h00); post(8'h01, 1); step(3); wmask(8'hFF); step(2); rdclr(); step(2);
    finish_run();
  end
endmodule